// File: doc/BRIEF.md
# Interleaved Two-Chip NAND Page Writer

This block turns an unbroken byte stream into programmed NAND pages, placing consecutive pages on two flash chips in turn. Each chip owns one page-sized buffer in on-chip RAM. While one chip runs its internal page program, which takes on the order of 200 us for a 2 KB page, the stream fills the other chip's buffer. The two program times therefore overlap the load time, and the stream sees only short stalls.

Every block has been erased beforehand, so the writer never issues an erase. Capture fills the mapped space once and then stops; it never wraps around. The logical blocks are visited in ascending order. Each one is translated to a physical block through a lookup port that the block drives. Both chips share the same physical block address for a given logical block. Within that block, page slot `i` on chip 0 and page slot `i` on chip 1 hold two consecutive stream pages.

Top module: `nand_ilv_writer`

## Requirements
- R1: Before `start` is pulsed, `s_ready` stays low, `map_req` stays low and `overflow` stays low, even when `s_valid` is high. After `start`, `map_req` rises with `map_lblk` = 0. `s_ready` stays low until the cycle after `map_ack`. While a lookup is pending, `map_req` and `map_lblk` hold steady.
- R2: Stream page k (bytes k*PAGE_BYTES to k*PAGE_BYTES+PAGE_BYTES-1, in stream order) is written to chip k mod 2. Even pages go to chip 0 and odd pages go to chip 1. The data bytes go out in stream order.
- R3: A page is written as follows:
  - one command cycle (`nf_cle`=1, `nf_we`=1) carrying 0x80;
  - five address cycles (`nf_ale`=1, `nf_we`=1);
  - PAGE_BYTES data cycles (`nf_we`=1 with both `nf_cle` and `nf_ale` low);
  - one command cycle carrying 0x10.
  
  `nf_cle` and `nf_ale` are never high together. `nf_we` and `nf_re` are never high together.
- R4: The five address bytes are 0x00, 0x00, then row bits 7:0, 15:8 and 23:16, where row = physical_block * PAGES_PER_BLK + page_slot. The page slot advances after each page sent to chip 1. After slot PAGES_PER_BLK-1, the next logical block is requested on the map port. No byte is accepted while a lookup is pending.
- R5: After 0x10, the writer waits for that chip's `nf_rdy` to fall and then rise. It then issues command 0x70 and one cycle with `nf_re`=1. If `nf_dq_i[0]` is 1 in that cycle, `prog_err` is set and stays set.
- R6: The 0x80 command is issued to a chip only while its `nf_rdy` is high, and only after the status read of its previous page.
- R7: A page load into one chip can proceed while the other chip reports busy.
- R8: If `s_valid` is high after start and before full, no lookup is pending, and the buffer for the next page is still occupied, then the byte is not taken (`s_ready`=0) and `overflow` is set and stays set. `s_ready` returns once that buffer has been sent.
- R9: When the last byte of the last page of logical block NUM_LBLK-1 has been accepted, `mem_full` rises on the next cycle. After that, `s_ready` stays low and further `s_valid` does not set `overflow`.
- R10: During and after reset, all strobes, `s_ready`, `map_req`, `mem_full`, `overflow` and `prog_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| start | input | 1 | pulse to begin capture |
| s_valid | input | 1 | stream byte offered |
| s_data | input | 8 | stream byte |
| s_ready | output | 1 | byte is taken on this cycle when valid |
| map_req | output | 1 | lookup of a logical block pending |
| map_lblk | output | LBLK_W | logical block being looked up |
| map_ack | input | 1 | lookup answer valid |
| map_pblk | input | BLK_W | physical block answer |
| nf_cle | output | 2 | command latch enable, one bit per chip |
| nf_ale | output | 2 | address latch enable, per chip |
| nf_we | output | 2 | write strobe, one byte per high cycle, per chip |
| nf_re | output | 2 | status read strobe, per chip |
| nf_dq_o | output | 2x8 | byte driven to each chip |
| nf_dq_i | input | 2x8 | byte returned by each chip |
| nf_rdy | input | 2 | ready (1) / busy (0) from each chip |
| mem_full | output | 1 | all mapped pages have been accepted |
| overflow | output | 1 | sticky: a byte arrived with no free buffer |
| prog_err | output | 1 | sticky: a status read reported failure |

## Verification
`s_ready`, `map_req` and `map_lblk` are decoded from registers, so the bench reads them at the falling edge in the same cycle in which it drives a byte. `mem_full` and `overflow` come from registers updated at the accepting or offending edge, so they are checked at the next falling edge. Chip strobes are decoded combinationally from each writer's state, so a per-chip protocol model captures them at every falling edge. That model compares each command, address and data byte with values computed from the stream index and the map rule. The status failure is sampled during the cycle in which `nf_re` is high. The model therefore checks that `prog_err` still shows the earlier value in that cycle, and it expects the new value only from the next status read onward.

// File: rtl/nand_ilw_pkg.sv
package nand_ilw_pkg;

   localparam logic [7:0] CMD_LOAD_START = 8'h80;
   localparam logic [7:0] CMD_LOAD_COMMIT = 8'h10;
   localparam logic [7:0] CMD_READ_STATUS = 8'h70;

   localparam int COL_CYCLES = 2;
   localparam int ROW_CYCLES = 3;
   localparam int ADDR_CYCLES = COL_CYCLES + ROW_CYCLES;
   localparam int ROW_BITS_MAX = 8 * ROW_CYCLES;
   localparam int NCHIP = 2;

   typedef enum logic [3:0] {
      WR_IDLE,
      WR_SETUP,
      WR_ADDR,
      WR_DATA,
      WR_COMMIT,
      WR_WAIT_BSY,
      WR_WAIT_RDY,
      WR_STAT_CMD,
      WR_STAT_RD
   } wr_state_e;

endpackage

// File: rtl/nand_page_buf.sv
module nand_page_buf #(
   parameter int DEPTH = 2048,
   parameter int AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [7:0]    wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [7:0]    rd_data
);

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem[wr_addr] <= wr_data;
      end
      rd_data <= mem[rd_addr];
   end

endmodule

// File: rtl/nand_fill_ctrl.sv
module nand_fill_ctrl
   import nand_ilw_pkg::*;
#(
   parameter int PAGE_BYTES = 2048,
   parameter int PAGES_PER_BLK = 128,
   parameter int NUM_LBLK = 1024,
   parameter int BLK_W = 12,
   parameter int LBLK_W = 10
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            start,
   input  logic                            s_valid,
   input  logic [7:0]                      s_data,
   output logic                            s_ready,
   output logic                            map_req,
   output logic [LBLK_W-1:0]               map_lblk,
   input  logic                            map_ack,
   input  logic [BLK_W-1:0]                map_pblk,
   output logic [NCHIP-1:0]                buf_wr,
   output logic [$clog2(PAGE_BYTES)-1:0]   buf_addr,
   output logic [7:0]                      buf_data,
   output logic [NCHIP-1:0]                buf_full,
   output logic [NCHIP-1:0][BLK_W+$clog2(PAGES_PER_BLK)-1:0] buf_row,
   input  logic [NCHIP-1:0]                buf_release,
   output logic                            mem_full,
   output logic                            overflow
);

   localparam int AW = $clog2(PAGE_BYTES);
   localparam int PG_W = $clog2(PAGES_PER_BLK);
   localparam int ROW_W = BLK_W + PG_W;
   localparam logic [AW-1:0] LAST_BYTE = AW'(PAGE_BYTES - 1);
   localparam logic [PG_W-1:0] LAST_PAGE = PG_W'(PAGES_PER_BLK - 1);
   localparam logic [LBLK_W-1:0] LAST_LBLK = LBLK_W'(NUM_LBLK - 1);

   logic              started;
   logic              done;
   logic              need_map;
   logic              sel;
   logic [AW-1:0]     wcnt;
   logic [PG_W-1:0]   page;
   logic [LBLK_W-1:0] lblk;
   logic [BLK_W-1:0]  pblk;
   logic              accept;
   logic              page_done;
   logic              open_ok;

   assign open_ok = started && !done && !need_map;
   assign s_ready = open_ok && !buf_full[sel];
   assign accept = s_valid && s_ready;
   assign page_done = accept && (wcnt == LAST_BYTE);
   assign map_req = need_map;
   assign map_lblk = lblk;
   assign mem_full = done;
   assign buf_addr = wcnt;
   assign buf_data = s_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         started <= 1'b0;
         done <= 1'b0;
         need_map <= 1'b0;
         sel <= 1'b0;
         wcnt <= '0;
         page <= '0;
         lblk <= '0;
         pblk <= '0;
         overflow <= 1'b0;
      end else begin
         if (start && !started) begin
            started <= 1'b1;
            need_map <= 1'b1;
         end
         if (need_map && map_ack) begin
            pblk <= map_pblk;
            need_map <= 1'b0;
         end
         if (accept) begin
            if (page_done) begin
               wcnt <= '0;
               sel <= ~sel;
               if (sel) begin
                  if (page == LAST_PAGE) begin
                     page <= '0;
                     if (lblk == LAST_LBLK) begin
                        done <= 1'b1;
                     end else begin
                        lblk <= lblk + 1'b1;
                        need_map <= 1'b1;
                     end
                  end else begin
                     page <= page + 1'b1;
                  end
               end
            end else begin
               wcnt <= wcnt + 1'b1;
            end
         end
         if (s_valid && open_ok && buf_full[sel]) begin
            overflow <= 1'b1;
         end
      end
   end

   for (genvar b = 0; b < NCHIP; b++) begin : g_slot
      assign buf_wr[b] = accept && (sel == 1'(b));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            buf_full[b] <= 1'b0;
            buf_row[b] <= '0;
         end else if (page_done && (sel == 1'(b))) begin
            buf_full[b] <= 1'b1;
            buf_row[b] <= ROW_W'({pblk, page});
         end else if (buf_release[b]) begin
            buf_full[b] <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/nand_chip_writer.sv
module nand_chip_writer
   import nand_ilw_pkg::*;
#(
   parameter int PAGE_BYTES = 2048,
   parameter int ROW_W = 19
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          page_ready,
   input  logic [ROW_W-1:0]              page_row,
   output logic                          page_release,
   output logic [$clog2(PAGE_BYTES)-1:0] rd_addr,
   input  logic [7:0]                    rd_data,
   output logic                          cle,
   output logic                          ale,
   output logic                          we,
   output logic                          re,
   output logic [7:0]                    dq_o,
   input  logic [7:0]                    dq_i,
   input  logic                          rdy,
   output logic                          fail
);

   localparam int AW = $clog2(PAGE_BYTES);
   localparam int CW = (AW > 3) ? AW : 3;
   localparam logic [CW-1:0] LAST_ADDR = CW'(ADDR_CYCLES - 1);
   localparam logic [CW-1:0] LAST_DATA = CW'(PAGE_BYTES - 1);

   wr_state_e                 st;
   logic [CW-1:0]             cnt;
   logic [ROW_BITS_MAX-1:0]   row;
   logic [7:0]                addr_byte;

   always_comb begin
      case (cnt[2:0])
         3'd2:    addr_byte = row[7:0];
         3'd3:    addr_byte = row[15:8];
         3'd4:    addr_byte = row[23:16];
         default: addr_byte = 8'h00;
      endcase
   end

   always_comb begin
      cle = 1'b0;
      ale = 1'b0;
      we = 1'b0;
      re = 1'b0;
      dq_o = 8'h00;
      page_release = 1'b0;
      case (st)
         WR_SETUP: begin
            cle = 1'b1;
            we = 1'b1;
            dq_o = CMD_LOAD_START;
         end
         WR_ADDR: begin
            ale = 1'b1;
            we = 1'b1;
            dq_o = addr_byte;
         end
         WR_DATA: begin
            we = 1'b1;
            dq_o = rd_data;
         end
         WR_COMMIT: begin
            cle = 1'b1;
            we = 1'b1;
            dq_o = CMD_LOAD_COMMIT;
            page_release = 1'b1;
         end
         WR_STAT_CMD: begin
            cle = 1'b1;
            we = 1'b1;
            dq_o = CMD_READ_STATUS;
         end
         WR_STAT_RD: re = 1'b1;
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= WR_IDLE;
         cnt <= '0;
         row <= '0;
         rd_addr <= '0;
         fail <= 1'b0;
      end else begin
         case (st)
            WR_IDLE: begin
               if (page_ready && rdy) begin
                  row <= ROW_BITS_MAX'(page_row);
                  rd_addr <= '0;
                  st <= WR_SETUP;
               end
            end
            WR_SETUP: begin
               cnt <= '0;
               st <= WR_ADDR;
            end
            WR_ADDR: begin
               if (cnt == LAST_ADDR) begin
                  cnt <= '0;
                  rd_addr <= rd_addr + 1'b1;
                  st <= WR_DATA;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            WR_DATA: begin
               rd_addr <= rd_addr + 1'b1;
               if (cnt == LAST_DATA) begin
                  st <= WR_COMMIT;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            WR_COMMIT: begin
               rd_addr <= '0;
               st <= WR_WAIT_BSY;
            end
            WR_WAIT_BSY: if (!rdy) st <= WR_WAIT_RDY;
            WR_WAIT_RDY: if (rdy) st <= WR_STAT_CMD;
            WR_STAT_CMD: st <= WR_STAT_RD;
            WR_STAT_RD: begin
               if (dq_i[0]) fail <= 1'b1;
               st <= WR_IDLE;
            end
            default: st <= WR_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/nand_ilv_writer.sv
module nand_ilv_writer
   import nand_ilw_pkg::*;
#(
   parameter int PAGE_BYTES = 2048,
   parameter int PAGES_PER_BLK = 128,
   parameter int NUM_LBLK = 1024,
   parameter int BLK_W = 12,
   parameter int LBLK_W = (NUM_LBLK > 1) ? $clog2(NUM_LBLK) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic                  s_valid,
   input  logic [7:0]            s_data,
   output logic                  s_ready,
   output logic                  map_req,
   output logic [LBLK_W-1:0]     map_lblk,
   input  logic                  map_ack,
   input  logic [BLK_W-1:0]      map_pblk,
   output logic [1:0]            nf_cle,
   output logic [1:0]            nf_ale,
   output logic [1:0]            nf_we,
   output logic [1:0]            nf_re,
   output logic [1:0][7:0]       nf_dq_o,
   input  logic [1:0][7:0]       nf_dq_i,
   input  logic [1:0]            nf_rdy,
   output logic                  mem_full,
   output logic                  overflow,
   output logic                  prog_err
);

   localparam int AW = $clog2(PAGE_BYTES);
   localparam int PG_W = $clog2(PAGES_PER_BLK);
   localparam int ROW_W = BLK_W + PG_W;

   if (PAGE_BYTES < 8 || (1 << AW) != PAGE_BYTES) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two of at least 8");
   end
   if (PAGES_PER_BLK < 2 || (1 << PG_W) != PAGES_PER_BLK) begin : g_bad_ppb
      $error("PAGES_PER_BLK must be a power of two of at least 2");
   end
   if (ROW_W > ROW_BITS_MAX) begin : g_bad_row
      $error("row address does not fit in the row address cycles");
   end
   if (NUM_LBLK < 1 || NUM_LBLK > (1 << LBLK_W)) begin : g_bad_lblk
      $error("NUM_LBLK does not fit LBLK_W");
   end

   logic [NCHIP-1:0]                 buf_wr;
   logic [AW-1:0]                    buf_addr;
   logic [7:0]                       buf_data;
   logic [NCHIP-1:0]                 buf_full;
   logic [NCHIP-1:0][ROW_W-1:0]      buf_row;
   logic [NCHIP-1:0]                 buf_release;
   logic [NCHIP-1:0][AW-1:0]         rd_addr;
   logic [NCHIP-1:0][7:0]            rd_data;
   logic [NCHIP-1:0]                 chip_fail;

   nand_fill_ctrl #(
      .PAGE_BYTES(PAGE_BYTES),
      .PAGES_PER_BLK(PAGES_PER_BLK),
      .NUM_LBLK(NUM_LBLK),
      .BLK_W(BLK_W),
      .LBLK_W(LBLK_W)
   ) i_fill (
      .clk(clk),
      .rst_n(rst_n),
      .start(start),
      .s_valid(s_valid),
      .s_data(s_data),
      .s_ready(s_ready),
      .map_req(map_req),
      .map_lblk(map_lblk),
      .map_ack(map_ack),
      .map_pblk(map_pblk),
      .buf_wr(buf_wr),
      .buf_addr(buf_addr),
      .buf_data(buf_data),
      .buf_full(buf_full),
      .buf_row(buf_row),
      .buf_release(buf_release),
      .mem_full(mem_full),
      .overflow(overflow)
   );

   for (genvar c = 0; c < NCHIP; c++) begin : g_chip
      nand_page_buf #(
         .DEPTH(PAGE_BYTES)
      ) i_buf (
         .clk(clk),
         .wr_en(buf_wr[c]),
         .wr_addr(buf_addr),
         .wr_data(buf_data),
         .rd_addr(rd_addr[c]),
         .rd_data(rd_data[c])
      );

      nand_chip_writer #(
         .PAGE_BYTES(PAGE_BYTES),
         .ROW_W(ROW_W)
      ) i_wr (
         .clk(clk),
         .rst_n(rst_n),
         .page_ready(buf_full[c]),
         .page_row(buf_row[c]),
         .page_release(buf_release[c]),
         .rd_addr(rd_addr[c]),
         .rd_data(rd_data[c]),
         .cle(nf_cle[c]),
         .ale(nf_ale[c]),
         .we(nf_we[c]),
         .re(nf_re[c]),
         .dq_o(nf_dq_o[c]),
         .dq_i(nf_dq_i[c]),
         .rdy(nf_rdy[c]),
         .fail(chip_fail[c])
      );
   end

   assign prog_err = |chip_fail;

endmodule

// File: rtl/nand_ilv_writer_chk.sv
module nand_ilv_writer_chk #(
   parameter int LBLK_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              s_valid,
   input logic              s_ready,
   input logic              map_req,
   input logic              map_ack,
   input logic [LBLK_W-1:0] map_lblk,
   input logic [1:0]        nf_cle,
   input logic [1:0]        nf_ale,
   input logic [1:0]        nf_we,
   input logic [1:0]        nf_re,
   input logic [1:0][7:0]   nf_dq_o,
   input logic [1:0]        nf_rdy,
   input logic              mem_full,
   input logic              overflow,
   input logic              prog_err
);

   // R1
   map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (map_req && !map_ack) |=> (map_req && $stable(map_lblk)));

   // R4
   no_take_in_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s_valid && s_ready) |-> !map_req);

   // R5
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prog_err |=> prog_err);

   // R8
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);

   // R9
   full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_full |=> (mem_full && !s_ready));

   for (genvar c = 0; c < 2; c++) begin : g_pin
      // R3
      latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !(nf_cle[c] && nf_ale[c]));
      // R3
      strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0({nf_we[c], nf_re[c]}));
      // R6
      load_on_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (nf_we[c] && nf_cle[c] && nf_dq_o[c] == 8'h80) |-> nf_rdy[c]);
   end

endmodule

bind nand_ilv_writer nand_ilv_writer_chk #(.LBLK_W(LBLK_W)) i_chk (
   .clk(clk),
   .rst_n(rst_n),
   .s_valid(s_valid),
   .s_ready(s_ready),
   .map_req(map_req),
   .map_ack(map_ack),
   .map_lblk(map_lblk),
   .nf_cle(nf_cle),
   .nf_ale(nf_ale),
   .nf_we(nf_we),
   .nf_re(nf_re),
   .nf_dq_o(nf_dq_o),
   .nf_rdy(nf_rdy),
   .mem_full(mem_full),
   .overflow(overflow),
   .prog_err(prog_err)
);

// File: tb/test_nand_ilv_writer.sv
module test_nand_ilv_writer;

   localparam int PB = 8;
   localparam int PPB = 4;
   localparam int NL = 2;
   localparam int BW = 10;
   localparam int LW = 1;
   localparam int NBYTES = PB * PPB * NL * 2;
   localparam int NPAGES = PPB * NL * 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic            s_valid = 1'b0;
   logic [7:0]      s_data = 8'h00;
   logic            s_ready;
   logic            map_req;
   logic [LW-1:0]   map_lblk;
   logic            map_ack = 1'b0;
   logic [BW-1:0]   map_pblk = '0;
   logic [1:0]      nf_cle, nf_ale, nf_we, nf_re;
   logic [1:0][7:0] nf_dq_o;
   logic [1:0][7:0] nf_dq_i = '0;
   logic [1:0]      rdy_m = 2'b11;
   logic            hold_low = 1'b0;
   logic [1:0]      nf_rdy;
   logic            mem_full, overflow, prog_err;

   assign nf_rdy = rdy_m & ~{2{hold_low}};

   always #5 clk = ~clk;

   nand_ilv_writer #(
      .PAGE_BYTES(PB), .PAGES_PER_BLK(PPB), .NUM_LBLK(NL), .BLK_W(BW), .LBLK_W(LW)
   ) i_nand_ilv_writer (
      .clk(clk), .rst_n(rst_n), .start(start),
      .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
      .map_req(map_req), .map_lblk(map_lblk), .map_ack(map_ack), .map_pblk(map_pblk),
      .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we(nf_we), .nf_re(nf_re),
      .nf_dq_o(nf_dq_o), .nf_dq_i(nf_dq_i), .nf_rdy(nf_rdy),
      .mem_full(mem_full), .overflow(overflow), .prog_err(prog_err)
   );

   int  n_chk = 0;
   int  n_fail = 0;
   logic [7:0] sent_b [NBYTES];
   int  pst [2];
   int  acnt [2];
   int  dcnt [2];
   int  pg_done [2];
   int  busy_left [2];
   bit  err_seen;
   bit  overlap_seen;
   int  lookups;
   int  mcnt;
   bit  fail_inject;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   function automatic int map_rule(input int lb);
      return 5 + 3 * lb;
   endfunction

   function automatic int exp_addr(input int pair, input int idx);
      int row;
      row = map_rule(pair / PPB) * PPB + (pair % PPB);
      case (idx)
         2: return row & 255;
         3: return (row >> 8) & 255;
         4: return (row >> 16) & 255;
         default: return 0;
      endcase
   endfunction

   // chip protocol model and checker
   always @(negedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < 2; c++) begin
            pst[c] = 0; acnt[c] = 0; dcnt[c] = 0; pg_done[c] = 0; busy_left[c] = 0;
         end
         rdy_m = 2'b11;
         nf_dq_i = '0;
         err_seen = 0;
         overlap_seen = 0;
      end else begin
         for (int c = 0; c < 2; c++) begin
            if (nf_we[c]) begin
               if (nf_cle[c]) begin
                  case (pst[c])
                     0: begin
                        chk(nf_dq_o[c] == 8'h80, "R3 load cmd", nf_dq_o[c], 128);
                        chk(nf_rdy[c], "R6 load while busy", nf_rdy[c], 1);
                        if (!nf_rdy[1-c]) overlap_seen = 1;
                        pst[c] = 1; acnt[c] = 0;
                     end
                     3: begin
                        chk(nf_dq_o[c] == 8'h10, "R3 commit cmd", nf_dq_o[c], 16);
                        nf_dq_i[c] = (fail_inject && c == 0 && pg_done[0] == 1) ? 8'h01 : 8'h00;
                        busy_left[c] = 10 + int'($urandom % 40);
                        rdy_m[c] = 1'b0;
                        pst[c] = 4;
                     end
                     4: begin
                        chk(nf_dq_o[c] == 8'h70, "R5 status cmd", nf_dq_o[c], 112);
                        pst[c] = 5;
                     end
                     default: chk(0, "R3 command out of order", nf_dq_o[c], pst[c]);
                  endcase
               end else if (nf_ale[c]) begin
                  chk(pst[c] == 1, "R3 address phase", pst[c], 1);
                  chk(nf_dq_o[c] == exp_addr(pg_done[c], acnt[c]), "R4 address byte",
                      nf_dq_o[c], exp_addr(pg_done[c], acnt[c]));
                  acnt[c]++;
                  if (acnt[c] == 5) begin pst[c] = 2; dcnt[c] = 0; end
               end else begin
                  chk(pst[c] == 2, "R3 data phase", pst[c], 2);
                  chk(nf_dq_o[c] == sent_b[(2 * pg_done[c] + c) * PB + dcnt[c]], "R2 data byte",
                      nf_dq_o[c], sent_b[(2 * pg_done[c] + c) * PB + dcnt[c]]);
                  dcnt[c]++;
                  if (dcnt[c] == PB) pst[c] = 3;
               end
            end
            if (nf_re[c]) begin
               chk(pst[c] == 5, "R5 status read order", pst[c], 5);
               chk(prog_err == err_seen, "R5 error flag", prog_err, err_seen);
               if (nf_dq_i[c][0]) err_seen = 1;
               pg_done[c]++;
               pst[c] = 0;
            end
            if (!rdy_m[c] && pst[c] >= 4) begin
               if (busy_left[c] == 0) rdy_m[c] = 1'b1;
               else busy_left[c]--;
            end
         end
      end
   end

   // map lookup responder
   always @(negedge clk) begin
      if (!rst_n) begin
         map_ack = 1'b0; mcnt = 0; lookups = 0;
      end else if (map_ack) begin
         map_ack = 1'b0;
      end else if (map_req) begin
         if (mcnt == 2) begin
            chk(int'(map_lblk) == lookups, "R4 lookup order", map_lblk, lookups);
            map_pblk = BW'(map_rule(int'(map_lblk)));
            map_ack = 1'b1;
            lookups++;
            mcnt = 0;
         end else begin
            mcnt++;
         end
      end
   end

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=0 exp=1");
      finish_run();
   end

   task automatic send_bytes(input int n, input bit gaps);
      for (int i = 0; i < n; i++) begin
         if (gaps && ($urandom % 4 == 0)) @(negedge clk);
         while (!s_ready) @(negedge clk);
         chk(!map_req, "R4 take during lookup", map_req, 0);
         s_valid = 1'b1;
         s_data = sent_b[i];
         @(negedge clk);
         s_valid = 1'b0;
      end
   endtask

   task automatic do_start();
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(map_req == 1'b1, "R1 lookup after start", map_req, 1);
      chk(map_lblk == '0, "R1 first block", map_lblk, 0);
      chk(s_ready == 1'b0, "R1 ready before answer", s_ready, 0);
   endtask

   initial begin
      int seed;
      seed = $urandom(32'd4711);
      for (int i = 0; i < NBYTES; i++) sent_b[i] = 8'($urandom);
      fail_inject = 1'b1;

      // phase A: full capture with random gaps and busy times
      repeat (3) @(negedge clk);
      chk(s_ready == 0 && map_req == 0, "R10 reset ready/map", {s_ready, map_req}, 0);
      chk(nf_we == 0 && nf_re == 0 && nf_cle == 0 && nf_ale == 0, "R10 reset strobes",
          {nf_we, nf_re}, 0);
      chk(mem_full == 0 && overflow == 0 && prog_err == 0, "R10 reset flags",
          {mem_full, overflow, prog_err}, 0);
      rst_n = 1'b1;
      s_valid = 1'b1;
      s_data = 8'hA5;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk(s_ready == 0, "R1 ready before start", s_ready, 0);
         chk(overflow == 0 && map_req == 0, "R1 idle flags", {overflow, map_req}, 0);
      end
      s_valid = 1'b0;
      do_start();
      send_bytes(NBYTES, 1'b1);
      chk(mem_full == 1, "R9 full after last byte", mem_full, 1);
      chk(s_ready == 0, "R9 ready after full", s_ready, 0);
      s_valid = 1'b1;
      repeat (4) @(negedge clk);
      s_valid = 1'b0;
      chk(overflow == 0, "R9 no overflow after full", overflow, 0);
      chk(s_ready == 0 && mem_full == 1, "R9 stays full", {s_ready, mem_full}, 1);
      while (pg_done[0] + pg_done[1] < NPAGES) @(negedge clk);
      chk(pg_done[0] == NPAGES / 2, "R2 chip0 pages", pg_done[0], NPAGES / 2);
      chk(pg_done[1] == NPAGES / 2, "R2 chip1 pages", pg_done[1], NPAGES / 2);
      chk(overlap_seen, "R7 overlapped load", overlap_seen, 1);
      chk(prog_err == 1, "R5 error reported", prog_err, 1);
      chk(lookups == NL, "R4 lookup count", lookups, NL);

      // phase B: both chips held busy, buffers fill, then overflow
      rst_n = 1'b0;
      fail_inject = 1'b0;
      hold_low = 1'b1;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      do_start();
      send_bytes(2 * PB, 1'b0);
      chk(s_ready == 0, "R8 ready with both buffers held", s_ready, 0);
      chk(overflow == 0, "R8 no overflow yet", overflow, 0);
      chk(nf_we == 0, "R6 no write while busy", nf_we, 0);
      s_valid = 1'b1;
      s_data = 8'h3C;
      @(negedge clk);
      s_valid = 1'b0;
      chk(overflow == 1, "R8 overflow set", overflow, 1);
      repeat (3) @(negedge clk);
      chk(overflow == 1, "R8 overflow sticky", overflow, 1);
      chk(pg_done[0] == 0 && pst[0] == 0 && pst[1] == 0, "R6 nothing issued while busy",
          pst[0] + pst[1], 0);
      hold_low = 1'b0;
      while (pg_done[0] + pg_done[1] < 2) @(negedge clk);
      chk(s_ready == 1, "R8 ready after drain", s_ready, 1);
      chk(prog_err == 0, "R5 clean status", prog_err, 0);
      chk(mem_full == 0, "R9 not full early", mem_full, 0);
      finish_run();
   end

endmodule